// File: doc/BRIEF.md
# Serial Port with RTS/CTS Flow Control

This block is an asynchronous serial transmitter and receiver pair with active-low request-to-send and clear-to-send handshaking. Both directions use a fixed character of one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line rests high between characters. Each bit lasts `CLKS_PER_BIT` system clocks. On the host side the block has a byte-wide valid/ready port for characters to send and another for characters received.

The transmitter starts a character only while the synchronized clear-to-send input is low. Once a character has begun it always finishes, so a deassertion of clear-to-send holds back the next character and not the current one. The receiver checks the start bit at its midpoint and samples each later bit at its own midpoint. It stores good characters in a small queue. At the stop-bit midpoint it decides whether to raise request-to-send. It raises the signal once the queue has one free slot or fewer, and the slot that stays free takes the character the far end may already have started.

Top module: `uart_fc`

## Requirements
- R1: The transmit line rests high. Each transmitted character is one low start bit, then eight data bits with the least significant bit first, then one high stop bit, and every bit lasts `CLKS_PER_BIT` clocks.
- R2: `tx_ready` is high only when the transmitter is idle and the synchronized `cts_n` is low. While `cts_n` stays high, a waiting `tx_valid` byte is not taken and the line stays high.
- R3: When `cts_n` falls while a byte is waiting, the start bit begins within 1.5 bit periods. The two-flop synchronizer delay counts against this budget.
- R4: If `cts_n` rises at least 0.5 bit period before the midpoint of the current character's stop bit, that character still completes and no further character starts until `cts_n` is low again.
- R5: The receiver checks the start bit half a bit period after the falling edge. If the line reads high there, the event is dropped as a glitch and nothing is stored. A later valid character is still received.
- R6: A character whose stop bit reads high is appended to a 4-entry queue. Characters are delivered in arrival order on `rx_valid`/`rx_data`, and `rx_data` holds steady while `rx_valid` is high and `rx_ready` is low.
- R7: If the queue holds 3 or more characters after the stop-bit midpoint, `rts_n` goes high within 0.5 bit period of that midpoint. It stays low while the queue holds 2 or fewer.
- R8: After reads bring the queue down to 2 or fewer entries, `rts_n` returns low within two clocks. It stays high while 3 remain.
- R9: A character whose stop bit reads low is discarded. The receiver then waits for the line to return high before it looks for a new start bit.
- R10: After reset, `txd` is high, `rts_n` is low, `rx_valid` is low, and `tx_ready` is low until a low `cts_n` has passed the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Host has a byte to send |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Byte is taken on a clock where valid and ready are both high |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear-to-send from the far end, active low |
| rxd | input | 1 | Serial receive line |
| rts_n | output | 1 | Request-to-send to the far end, active low |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Oldest received byte |
| rx_ready | input | 1 | Host takes the byte on a clock where valid and ready are both high |

## Verification
The no-overflow property assumes the far end obeys `rts_n`: after `rts_n` rises, at most one more character arrives before the host reads. The stimulus follows this rule by sending exactly one character after the rise. The hold and step properties assume that `rxd` and `cts_n` change no faster than the synchronizer can follow. The stimulus drives them on falling clock edges and holds every level for at least four clocks. The `rts_n` timing properties take the queue as the only source of change, so the host reads only through `rx_ready`.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HUNT
  } rx_state_e;

  // Clock count from a start-bit edge to its midpoint.
  function automatic int unsigned half_period(int unsigned clks);
    return clks / 2;
  endfunction

  // True when the queue has one free slot or fewer.
  function automatic logic hold_sender(int unsigned occupancy, int unsigned depth);
    return (occupancy + 1) >= depth;
  endfunction

endpackage

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_ok,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              line,
  output logic              start_go
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              bit_end;

  assign bit_end  = (cnt == CNT_W'(CLKS_PER_BIT - 1));
  assign tx_ready = (state == TX_IDLE) && cts_ok;
  assign start_go = tx_ready && tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      line  <= 1'b1;
    end else begin
      case (state)
        TX_IDLE: begin
          cnt  <= '0;
          line <= 1'b1;
          if (start_go) begin
            shreg <= tx_data;
            line  <= 1'b0;
            state <= TX_START;
          end
        end
        TX_START: begin
          if (bit_end) begin
            cnt   <= '0;
            idx   <= '0;
            line  <= shreg[0];
            shreg <= shreg >> 1;
            state <= TX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            if (idx == IDX_W'(DATA_W - 1)) begin
              line  <= 1'b1;
              state <= TX_STOP;
            end else begin
              line  <= shreg[0];
              shreg <= shreg >> 1;
              idx   <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_STOP: begin
          if (bit_end) begin
            cnt   <= '0;
            state <= TX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_IDLE) |-> line);

  assert_start_needs_cts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_START && $past(state) == TX_IDLE) |-> $past(cts_ok));

  assert_stop_bit_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_STOP) |-> line);
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
  import uart_fc_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_s,
  output logic              byte_ok,
  output logic [DATA_W-1:0] byte_val,
  output logic              stop_mid
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF  = half_period(CLKS_PER_BIT);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              half_hit;
  logic              full_hit;

  assign half_hit = (state == RX_START) && (cnt == CNT_W'(HALF - 1));
  assign full_hit = (cnt == CNT_W'(CLKS_PER_BIT - 1));
  assign stop_mid = (state == RX_STOP) && full_hit;
  assign byte_ok  = stop_mid && rxd_s;
  assign byte_val = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (!rxd_s) state <= RX_START;
        end
        RX_START: begin
          if (half_hit) begin
            cnt   <= '0;
            idx   <= '0;
            state <= rxd_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (full_hit) begin
            cnt   <= '0;
            shreg <= {rxd_s, shreg[DATA_W-1:1]};
            if (idx == IDX_W'(DATA_W - 1)) state <= RX_STOP;
            else idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (full_hit) begin
            cnt   <= '0;
            state <= rxd_s ? RX_IDLE : RX_HUNT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_HUNT: begin
          cnt <= '0;
          if (rxd_s) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assert_glitch_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_hit && rxd_s) |=> (state == RX_IDLE));

  assert_bad_stop_hunts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mid && !rxd_s) |=> (state == RX_HUNT));
endmodule

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop,
  output logic                       out_valid,
  output logic [DATA_W-1:0]          out_data,
  output logic [$clog2(DEPTH+1)-1:0] occupancy
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_p;
  logic [AW-1:0]     rd_p;
  logic [CW-1:0]     cnt;
  logic              wr_ok;
  logic              rd_ok;

  assign wr_ok     = push && (cnt != CW'(DEPTH));
  assign rd_ok     = pop && (cnt != '0);
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rd_p];
  assign occupancy = cnt;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_p] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (wr_ok) wr_p <= (wr_p == AW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
      if (rd_ok) rd_p <= (rd_p == AW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
      cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/uart_fc.sv
module uart_fc
  import uart_fc_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_W       = 8,
  parameter int RX_DEPTH     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              txd,
  input  logic              cts_n,
  input  logic              rxd,
  output logic              rts_n,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready
);
  localparam int CW = $clog2(RX_DEPTH + 1);

  logic              cts_s;
  logic              rxd_s;
  logic              tx_start;
  logic              rx_push;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_stop_mid;
  logic [CW-1:0]     occ;
  logic              pop_ok;
  logic              rts_q;

  uart_fc_sync #(.RST_VAL(1'b1)) u_cts_sync (
    .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_s)
  );

  uart_fc_sync #(.RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  uart_fc_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cts_ok(!cts_s), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .line(txd), .start_go(tx_start)
  );

  uart_fc_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd_s(rxd_s), .byte_ok(rx_push),
    .byte_val(rx_byte), .stop_mid(rx_stop_mid)
  );

  uart_fc_fifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_byte),
    .pop(rx_ready), .out_valid(rx_valid), .out_data(rx_data), .occupancy(occ)
  );

  assign pop_ok = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_q <= 1'b0;
    else        rts_q <= hold_sender(int'(occ), RX_DEPTH);
  end

  assign rts_n = rts_q;

  assert_rts_rise_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_q) |-> $past(rx_push, 2));

  assert_rts_fall_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_q) |-> $past(pop_ok, 2));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (int'(occ) < RX_DEPTH));

  assert_push_only_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> rx_stop_mid);

  assert_tx_start_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !cts_s);
endmodule

// File: tb/uart_fc_tb.sv
module uart_fc_tb_top;
  localparam int CPB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready;
  logic       txd;
  logic       cts_n = 1'b1;
  logic       rxd = 1'b1;
  logic       rts_n;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_ready = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  int n_accepted = 0;
  int n_frames = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];
  logic rts_pre, rts_post;

  always #5 clk = ~clk;

  uart_fc #(.CLKS_PER_BIT(CPB), .DATA_W(8), .RX_DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .txd(txd), .cts_n(cts_n), .rxd(rxd), .rts_n(rts_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Host-side handshake log: bytes taken by the transmitter.
  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      exp_tx.push_back(tx_data);
      n_accepted++;
    end
  end

  // Line decoder: samples every bit at its midpoint (R1).
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !txd) begin
        logic [7:0] got;
        repeat (CPB / 2) @(negedge clk);
        chk(txd == 1'b0, "R1 start bit", int'(txd), 0);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          got[i] = txd;
        end
        repeat (CPB) @(negedge clk);
        chk(txd == 1'b1, "R1 stop bit", int'(txd), 1);
        n_frames++;
        if (exp_tx.size() > 0) begin
          chk(got == exp_tx[0], "R1 data", int'(got), int'(exp_tx[0]));
          void'(exp_tx.pop_front());
        end else begin
          chk(1'b0, "R1 unexpected frame", int'(got), -1);
        end
      end
    end
  end

  task automatic send_rx(input logic [7:0] b, input logic stop_val);
    rxd = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (CPB) @(negedge clk);
    end
    rts_pre = rts_n;
    rxd = stop_val;
    repeat (14) @(negedge clk);
    rts_post = rts_n;
    repeat (2) @(negedge clk);
    rxd = 1'b1;
    repeat (CPB) @(negedge clk);
    if (stop_val) exp_rx.push_back(b);
  endtask

  task automatic pop_one(input string req);
    chk(rx_valid == 1'b1, req, int'(rx_valid), 1);
    if (exp_rx.size() > 0) begin
      chk(rx_data == exp_rx[0], req, int'(rx_data), int'(exp_rx[0]));
      void'(exp_rx.pop_front());
    end
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    int lat;
    int low_seen;
    int rdy_seen;
    int drift;
    logic [7:0] first;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(txd == 1'b1, "R10 txd", int'(txd), 1);
    chk(rts_n == 1'b0, "R10 rts_n", int'(rts_n), 0);
    chk(rx_valid == 1'b0, "R10 rx_valid", int'(rx_valid), 0);
    chk(tx_ready == 1'b0, "R10 tx_ready", int'(tx_ready), 0);

    // R2: byte waits while cts_n is high
    tx_valid = 1'b1;
    tx_data  = 8'hA5;
    low_seen = 0;
    rdy_seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (!txd) low_seen++;
      if (tx_ready) rdy_seen++;
    end
    chk(low_seen == 0, "R2 line held", low_seen, 0);
    chk(rdy_seen == 0, "R2 ready held", rdy_seen, 0);

    // R3: cts_n falls, start bit within 1.5 bits
    cts_n = 1'b0;
    lat = 0;
    while (txd && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lat <= (3 * CPB) / 2, "R3 first latency", lat, (3 * CPB) / 2);
    chk(n_accepted == 1, "R2 accepted", n_accepted, 1);
    tx_data = 8'h3C;

    // R4: cts_n rises 1.5 bits before stop midpoint
    repeat (8 * CPB - lat) @(negedge clk);
    cts_n = 1'b1;
    low_seen = 0;
    repeat (5 * CPB) begin
      @(negedge clk);
      if (tx_ready) low_seen++;
    end
    chk(n_accepted == 1, "R4 no second start", n_accepted, 1);
    chk(n_frames == 1, "R4 first frame completed", n_frames, 1);
    chk(low_seen == 0, "R4 ready stays low", low_seen, 0);
    chk(txd == 1'b1, "R4 line idle", int'(txd), 1);

    // R3 again after re-enable
    cts_n = 1'b0;
    lat = 0;
    while (txd && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lat <= (3 * CPB) / 2, "R3 second latency", lat, (3 * CPB) / 2);
    chk(n_accepted == 2, "R4 resumed", n_accepted, 2);
    tx_valid = 1'b0;
    repeat (11 * CPB) @(negedge clk);
    chk(n_frames == 2, "R1 frames", n_frames, 2);

    // R7: fill the receive queue
    send_rx(8'h11, 1'b1);
    chk(rts_post == 1'b0, "R7 one entry", int'(rts_post), 0);
    send_rx(8'h22, 1'b1);
    chk(rts_post == 1'b0, "R7 two entries", int'(rts_post), 0);
    send_rx(8'h33, 1'b1);
    chk(rts_pre == 1'b0, "R7 before midpoint", int'(rts_pre), 0);
    chk(rts_post == 1'b1, "R7 after midpoint", int'(rts_post), 1);
    send_rx(8'hC4, 1'b1);
    chk(rts_n == 1'b1, "R7 still held", int'(rts_n), 1);

    // R6: hold while not read
    first = rx_data;
    drift = 0;
    repeat (20) begin
      @(negedge clk);
      if (!rx_valid || rx_data != first) drift++;
    end
    chk(drift == 0, "R6 hold", drift, 0);

    // R8: release as reads drain
    pop_one("R6 order 1");
    repeat (3) @(negedge clk);
    chk(rts_n == 1'b1, "R8 three left", int'(rts_n), 1);
    pop_one("R6 order 2");
    chk(rts_n == 1'b0, "R8 two left", int'(rts_n), 0);
    pop_one("R6 order 3");
    pop_one("R6 order 4");
    chk(rx_valid == 1'b0, "R6 drained", int'(rx_valid), 0);

    // R5: short low pulse
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * CPB) @(negedge clk);
    chk(rx_valid == 1'b0, "R5 glitch dropped", int'(rx_valid), 0);
    send_rx(8'h5A, 1'b1);
    pop_one("R5 recovery");

    // R9: low stop bit
    send_rx(8'h77, 1'b0);
    repeat (2 * CPB) @(negedge clk);
    chk(rx_valid == 1'b0, "R9 frame dropped", int'(rx_valid), 0);
    send_rx(8'h6B, 1'b1);
    pop_one("R9 recovery");

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule